// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, once for each frame, whether the frame's 48-bit destination address lets it through. The receive path presents the address together with a one-cycle strobe. Exactly one clock later the block returns a pass/drop flag and a code that names the rule which accepted the address.

Acceptance draws on several sources. A promiscuous switch passes everything. Broadcast addresses are accepted by default. A multicast address can be accepted wholesale, or through a hash table of 64, 128 or 256 bins. A small table of exact addresses covers unicast stations, and a combined mode lets hash and exact hits both accept. A receive-all switch forces every frame through but still reports what the filter itself decided.

Configuration arrives through three plain write ports: the mode bits, one 32-bit hash table word at a time, and one exact-address entry at a time. A write takes effect on the clock edge that follows it.

Top module: `rx_da_filter`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after a cycle with `da_valid` high, and low otherwise.
- R2: After reset the mode bits, the hash table and every exact entry are zero, and the outputs are low. With this empty configuration a non-broadcast address is dropped with reason 0, and the broadcast address passes with reason 2.
- R3: Mode bit 0 (promiscuous) passes every address with reason 1. It overrides every other rule, including broadcast disable.
- R4: The address with all 48 bits set is broadcast. It passes with reason 2 unless mode bit 4 (broadcast disable) is set, in which case it is dropped with reason 0.
- R5: A non-broadcast address whose bit 40 (the least significant bit of the first octet, held in `da[47:40]`) is 1 is multicast. With mode bit 1 set, a multicast address passes with reason 3 without any hash lookup.
- R6: The hash index is built from the standard Ethernet CRC-32 taken over the six address octets, first octet `da[47:40]` first and each octet least significant bit first. The CRC is bit-reversed and its top HASH_BITS bits are kept. Index bits above bit 4 select the table word written at `hash_word`, and index bits 4..0 select the bit within that word. With mode bit 2 set, a multicast address passes with reason 4 when its table bit is 1.
- R7: An exact entry matches when it equals the address and is not all zeros; a zero entry never matches. A matching unicast address passes with reason 5. A matching multicast address also passes with reason 5, but only when mode bit 2 is clear or mode bit 3 is set.
- R8: With mode bit 3 (hash-or-exact) set, a unicast address passes on a hash table hit (reason 4) or an exact hit (reason 5). A multicast address under mode bit 2 passes on either kind of hit.
- R9: Mode bit 5 (receive-all) forces `dec_pass` to 1 and leaves `dec_reason` at the code the other rules produce, 0 when they would drop the address.
- R10: A lookup presented in the same cycle as a configuration write is judged on the configuration from before that write. The next lookup sees the new value.
- R11: When more than one rule fires, the reason follows a fixed order: 1, then 2, then 3, then 4, then 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode_we | input | 1 | Write strobe for the mode bits |
| cfg_mode | input | 6 | Mode: 0 promiscuous, 1 all-multicast, 2 hash multicast, 3 hash-or-exact, 4 broadcast disable, 5 receive-all |
| hash_we | input | 1 | Write strobe for one hash table word |
| hash_word | input | HASH_BITS-5 | Hash table word number |
| hash_data | input | 32 | Hash table word value |
| perf_we | input | 1 | Write strobe for one exact-address entry |
| perf_idx | input | clog2(PERF_ENTRIES) | Exact entry number |
| perf_addr | input | 48 | Exact entry value, first octet in bits 47:40 |
| da_valid | input | 1 | Address strobe, one cycle per frame |
| da | input | 48 | Destination address, first octet in bits 47:40 |
| dec_valid | output | 1 | Decision valid |
| dec_pass | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 none, 1 promiscuous, 2 broadcast, 3 all-multicast, 4 hash, 5 exact |

## Verification
A configuration write and an address lookup can fall in the same cycle, and the lookup must then use the table or mode value from before the write. The bench sets a hash bit or a mode bit in the same cycle as it presents an address that depends on that bit. It expects the old verdict first, then presents the address again and expects the new one. Beyond this directed case, random traffic changes the mode and the tables between bursts of broadcast, multicast, zero and exact-copy addresses, and the bench computes each verdict with a CRC written in the non-reflected form.

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int HASH_BITS    = 6,
  parameter int PERF_ENTRIES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_mode_we,
  input  logic [5:0]                      cfg_mode,
  input  logic                            hash_we,
  input  logic [HASH_BITS-6:0]            hash_word,
  input  logic [31:0]                     hash_data,
  input  logic                            perf_we,
  input  logic [$clog2(PERF_ENTRIES)-1:0] perf_idx,
  input  logic [47:0]                     perf_addr,
  input  logic                            da_valid,
  input  logic [47:0]                     da,
  output logic                            dec_valid,
  output logic                            dec_pass,
  output logic [2:0]                      dec_reason
);

  localparam int BINS = 1 << HASH_BITS;
  localparam logic [2:0] RS_NONE = 3'd0, RS_PROM = 3'd1, RS_BC = 3'd2,
                         RS_ALLMC = 3'd3, RS_HASH = 3'd4, RS_PERF = 3'd5;

  logic [5:0]      mode_q;
  logic [BINS-1:0] hash_q;
  logic [47:0]     perf_q [PERF_ENTRIES];

  wire promisc = mode_q[0];
  wire all_mc  = mode_q[1];
  wire hash_mc = mode_q[2];
  wire hop     = mode_q[3];
  wire bc_dis  = mode_q[4];
  wire rx_all  = mode_q[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      hash_q <= '0;
      for (int i = 0; i < PERF_ENTRIES; i++) perf_q[i] <= '0;
    end else begin
      if (cfg_mode_we) mode_q <= cfg_mode;
      if (hash_we) hash_q[int'(hash_word)*32 +: 32] <= hash_data;
      if (perf_we) perf_q[perf_idx] <= perf_addr;
    end
  end

  function automatic logic [HASH_BITS-1:0] hash_index(input logic [47:0] a);
    logic [31:0] r;
    logic [HASH_BITS-1:0] idx;
    r = '1;
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = r[0] ^ a[40 - 8*b + i];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB8_8320;
      end
    end
    r = ~r;
    for (int k = 0; k < HASH_BITS; k++) idx[HASH_BITS-1-k] = r[k];
    return idx;
  endfunction

  logic [HASH_BITS-1:0]    hidx;
  logic [PERF_ENTRIES-1:0] phit;
  assign hidx = hash_index(da);

  for (genvar g = 0; g < PERF_ENTRIES; g++) begin : g_perf
    assign phit[g] = (perf_q[g] != 48'd0) && (perf_q[g] == da);
  end

  wire hash_hit = hash_q[hidx];
  wire perf_hit = |phit;
  wire is_bc    = &da;
  wire is_mc    = da[40];

  logic [2:0] rsn;
  always_comb begin
    rsn = RS_NONE;
    if (promisc)     rsn = RS_PROM;
    else if (is_bc)  rsn = bc_dis ? RS_NONE : RS_BC;
    else if (is_mc) begin
      if (all_mc)                          rsn = RS_ALLMC;
      else if (hash_mc && hash_hit)        rsn = RS_HASH;
      else if ((!hash_mc || hop) && perf_hit) rsn = RS_PERF;
    end else begin
      if (hop && hash_hit) rsn = RS_HASH;
      else if (perf_hit)   rsn = RS_PERF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_pass   <= 1'b0;
      dec_reason <= RS_NONE;
    end else begin
      dec_valid  <= da_valid;
      dec_pass   <= da_valid && ((rsn != RS_NONE) || rx_all);
      dec_reason <= da_valid ? rsn : RS_NONE;
    end
  end

endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        da_valid,
  input logic [47:0] da,
  input logic        promisc,
  input logic        bc_dis,
  input logic        rx_all,
  input logic        dec_valid,
  input logic        dec_pass,
  input logic [2:0]  dec_reason
);

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !dec_valid);
  p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && promisc) |=> (dec_pass && dec_reason == 3'd1));
  p_bcast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da) && bc_dis && !promisc && !rx_all) |=> !dec_pass);
  p_zero_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da == 48'd0) |=> (dec_reason != 3'd5));
  p_recv_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && rx_all) |=> dec_pass);
  p_drop_reason_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !rx_all) |=> (dec_pass == (dec_reason != 3'd0)));

endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
  .promisc(mode_q[0]), .bc_dis(mode_q[4]), .rx_all(mode_q[5]),
  .dec_valid(dec_valid), .dec_pass(dec_pass), .dec_reason(dec_reason)
);

// File: tb/sim_rx_da_filter.sv
module sim_rx_da_filter;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 6;
  localparam int PE = 4;
  localparam int BINS = 1 << HB;

  logic clk = 0, rst_n = 0;
  logic cfg_mode_we = 0; logic [5:0] cfg_mode = 0;
  logic hash_we = 0; logic [HB-6:0] hash_word = 0; logic [31:0] hash_data = 0;
  logic perf_we = 0; logic [$clog2(PE)-1:0] perf_idx = 0; logic [47:0] perf_addr = 0;
  logic da_valid = 0; logic [47:0] da = 0;
  logic dec_valid, dec_pass; logic [2:0] dec_reason;

  int checks = 0, fails = 0;
  logic [5:0] sh_mode;
  logic [BINS-1:0] sh_hash;
  logic [47:0] sh_perf [PE];

  rx_da_filter #(.HASH_BITS(HB), .PERF_ENTRIES(PE)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic int ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] oct = a[47 - 8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic top = c[31] ^ oct[i];
        c = {c[30:0], 1'b0};
        if (top) c = c ^ 32'h04C1_1DB7;
      end
    end
    c = ~c;
    return int'(c >> (32 - HB));
  endfunction

  function automatic logic [2:0] ref_rsn(input logic [47:0] a);
    logic hh = sh_hash[ref_idx(a)];
    logic ph = 0;
    for (int i = 0; i < PE; i++) if (sh_perf[i] != 0 && sh_perf[i] == a) ph = 1;
    if (sh_mode[0]) return 3'd1;
    if (a == '1) return sh_mode[4] ? 3'd0 : 3'd2;
    if (a[40]) begin
      if (sh_mode[1]) return 3'd3;
      if (sh_mode[2] && hh) return 3'd4;
      if ((!sh_mode[2] || sh_mode[3]) && ph) return 3'd5;
      return 3'd0;
    end
    if (sh_mode[3] && hh) return 3'd4;
    if (ph) return 3'd5;
    return 3'd0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [5:0] m);
    cfg_mode_we = 1; cfg_mode = m; @(negedge clk); cfg_mode_we = 0; sh_mode = m;
  endtask

  task automatic wr_hash(input int w, input logic [31:0] d);
    hash_we = 1; hash_word = w[HB-6:0]; hash_data = d; @(negedge clk); hash_we = 0;
    sh_hash[w*32 +: 32] = d;
  endtask

  task automatic wr_perf(input int i, input logic [47:0] a);
    perf_we = 1; perf_idx = i[$clog2(PE)-1:0]; perf_addr = a; @(negedge clk); perf_we = 0;
    sh_perf[i] = a;
  endtask

  task automatic set_bin(input int idx, input logic v);
    logic [31:0] w = sh_hash[(idx/32)*32 +: 32];
    w[idx%32] = v;
    wr_hash(idx/32, w);
  endtask

  task automatic lookup(input logic [47:0] a, input string req);
    logic [2:0] er = ref_rsn(a);
    logic ep = (er != 0) || sh_mode[5];
    da_valid = 1; da = a;
    @(negedge clk);
    da_valid = 0;
    chk({req, " valid"}, dec_valid, 1);
    chk({req, " reason"}, dec_reason, er);
    chk({req, " pass"}, dec_pass, ep);
  endtask

  initial begin
    logic [47:0] uc, mc;
    int bi;
    void'($urandom(32'h1F2E3D4C));
    sh_mode = 0; sh_hash = 0;
    for (int i = 0; i < PE; i++) sh_perf[i] = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset valid", dec_valid, 0);
    chk("R2 reset pass", dec_pass, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle valid", dec_valid, 0);

    uc = 48'h02_11_22_33_44_55; mc = 48'h01_00_5E_01_02_03;
    lookup(uc, "R2 empty unicast");
    chk("R2 empty unicast drop", dec_pass, 0);
    lookup('1, "R2 broadcast default");
    chk("R2 broadcast reason", dec_reason, 2);
    @(negedge clk);
    chk("R1 valid drops", dec_valid, 0);

    wr_mode(6'b010000);
    lookup('1, "R4 broadcast disabled");
    chk("R4 broadcast dropped", dec_pass, 0);
    wr_mode(6'b010001);
    lookup('1, "R3 promisc over bc disable");
    chk("R3 promisc reason", dec_reason, 1);

    wr_mode(0);
    lookup(48'd0, "R7 zero address, zero entries");
    chk("R7 zero never matches", dec_reason, 0);
    wr_perf(1, uc);
    lookup(uc, "R7 exact hit");
    chk("R7 exact reason", dec_reason, 5);

    bi = ref_idx(mc);
    wr_mode(6'b000100);
    lookup(mc, "R6 hash miss");
    chk("R6 hash miss drop", dec_pass, 0);
    set_bin(bi, 1);
    lookup(mc, "R6 hash hit");
    chk("R6 hash hit reason", dec_reason, 4);
    wr_mode(6'b000110);
    lookup(mc, "R11 allmc before hash");
    chk("R11 allmc reason", dec_reason, 3);
    wr_mode(6'b000010);
    lookup(48'h03_AA_BB_CC_DD_EE, "R5 allmc");

    wr_mode(6'b001000);
    bi = ref_idx(48'h02_DE_AD_BE_EF_01);
    set_bin(bi, 1);
    lookup(48'h02_DE_AD_BE_EF_01, "R8 unicast hash");
    chk("R8 unicast hash reason", dec_reason, 4);
    wr_mode(6'b001100);
    wr_perf(2, mc ^ 48'h000000000100);
    lookup(mc ^ 48'h000000000100, "R8 multicast exact under hash");

    wr_mode(6'b100000);
    lookup(48'h02_99_88_77_66_55, "R9 receive-all");
    chk("R9 forced pass", dec_pass, 1);
    chk("R9 raw reason", dec_reason, 0);

    // R10: a write in the same cycle as a lookup
    wr_mode(6'b000100);
    set_bin(ref_idx(mc), 0);
    hash_we = 1; hash_word = (HB-6+1)'(ref_idx(mc) / 32);
    hash_data = sh_hash[(ref_idx(mc)/32)*32 +: 32] | (32'd1 << (ref_idx(mc) % 32));
    da_valid = 1; da = mc;
    @(negedge clk);
    hash_we = 0; da_valid = 0;
    chk("R10 old table used", dec_reason, 0);
    sh_hash[ref_idx(mc)] = 1;
    lookup(mc, "R10 new table next");
    chk("R10 new hit", dec_reason, 4);
    cfg_mode_we = 1; cfg_mode = 6'b000001; da_valid = 1; da = uc ^ 48'h1;
    @(negedge clk);
    cfg_mode_we = 0; da_valid = 0; sh_mode = 6'b000001;
    chk("R10 old mode used", dec_reason, 0);

    for (int round = 0; round < 40; round++) begin
      wr_mode(6'($urandom));
      for (int w = 0; w < BINS/32; w++) wr_hash(w, $urandom & $urandom);
      for (int i = 0; i < PE; i++)
        wr_perf(i, ($urandom % 3 == 0) ? 48'd0 : {$urandom, 16'($urandom)} & ~48'h010000000000);
      for (int n = 0; n < 60; n++) begin
        logic [47:0] a = {$urandom, 16'($urandom)};
        case ($urandom % 6)
          0: a[40] = 0;
          1: a[40] = 1;
          2: a = '1;
          3: a = sh_perf[$urandom % PE];
          4: a = sh_perf[$urandom % PE] | 48'h010000000000;
          default: a = 48'd0;
        endcase
        lookup(a, "R6 R8 R11 random");
        if ($urandom % 8 == 0) begin
          @(negedge clk);
          chk("R1 gap", dec_valid, 0);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule